// File: doc/BRIEF.md
# Rotating-Priority Interrupt Request Resolver

This block holds the pending, masked and in-service state for eight interrupt lines and picks the one line, if any, that should be raised to the processor. Each line has its own trigger mode. In level mode the pending bit follows the line. In edge mode a rising edge latches a pending bit that stays set until the line is acknowledged. The priority order is circular and starts from a programmable base line. A request is raised only when it outranks every interrupt already being serviced.

The block around it does the register programming and the cascading. It feeds this block the mask value, the mode flags, base-load pulses, acknowledge pulses and in-service clear pulses. It reads back the winner and the pending and in-service vectors. All state is held in registers. The winner is decoded combinationally from that state and the current mask, so the request output moves in the same cycle that the state moves.

Top module: `irq_resolver`

## Requirements
- R1: For a line whose `trig_level` bit is 1 (level mode), the pending bit in `pend_vec` equals the value that `req_in` had at the previous rising clock edge.
- R2: For a line whose `trig_level` bit is 0 (edge mode), the pending bit sets when `req_in` was high at an edge and low at the edge before it. Holding the line high or letting it fall never clears the bit.
- R3: Let the rotated rank of line i be (i - base) mod 8, where base is the 3-bit priority base. `win_line` is the line with the lowest rank among pending lines whose `mask_in` bit is 0. A line whose `mask_in` bit is 1 never wins.
- R4: `win_valid` is 1 only when the winning rank is strictly lower than the lowest rank of any set `serv_vec` bit. When no bit counts as in service, the reference rank is 8 and any unmasked pending line is raised.
- R5: When both `nest_special` and `is_master` are 1, in-service bit 2 is left out of the reference rank.
- R6: An `ack` pulse while `win_valid` is 1 sets the `serv_vec` bit of `win_line` when `auto_eoi` is 0. It clears that line's pending bit only if the line is in edge mode. If a new rising edge arrives in the same cycle, the pending bit stays set.
- R7: An `ack` pulse while `win_valid` is 1 and `auto_eoi` is 1 leaves `serv_vec` unchanged. If `rot_on_aeoi` is also 1, the base becomes (`win_line` + 1) mod 8.
- R8: A `serv_clr` pulse clears `serv_vec` bit `serv_clr_line`. An acknowledge that sets the same bit in the same cycle takes precedence.
- R9: A `base_load` pulse sets the base to `base_val`. A rotation from R7 in the same cycle takes precedence.
- R10: A synchronous active-high `rst` clears the pending bits, in-service bits, remembered input levels and base to zero.
- R11: An `ack` pulse while `win_valid` is 0 changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| req_in | input | 8 | Interrupt request lines |
| trig_level | input | 8 | Per-line mode: 1 level, 0 edge |
| mask_in | input | 8 | Per-line mask: 1 blocks the line |
| base_load | input | 1 | Load pulse for the priority base |
| base_val | input | 3 | Value loaded into the priority base |
| nest_special | input | 1 | Special nesting mode flag |
| is_master | input | 1 | Marks this instance as the cascade master |
| auto_eoi | input | 1 | Automatic end-of-interrupt on acknowledge |
| rot_on_aeoi | input | 1 | Rotate the base on automatic end-of-interrupt |
| ack | input | 1 | Acknowledge pulse for the current winner |
| serv_clr | input | 1 | Clear pulse for one in-service bit |
| serv_clr_line | input | 3 | Line whose in-service bit is cleared |
| win_valid | output | 1 | A request beats the in-service level |
| win_line | output | 3 | Winning line number |
| pend_vec | output | 8 | Pending request vector |
| serv_vec | output | 8 | In-service vector |

## Verification
The assertions run on every cycle and check four things. Level-mode pending bits track the input one edge later. An edge-mode pending bit drops only through an acknowledge. A raised winner is always pending, unmasked and not in service. An acknowledge either marks the winner in service or, under automatic end-of-interrupt, adds no in-service bit. Only the bench can show that the winner is the correct one under circular rotation, with nesting and the special cascade exclusion applied. The bench also covers the base rotation after automatic end-of-interrupt and the precedence between simultaneous load, clear and acknowledge events. For these it compares every cycle against a reference model driven by randomized traffic and a few directed sequences.

// File: rtl/irq_res_pkg.sv
package irq_res_pkg;
  localparam int NLINES = 8;
  localparam int LW = $clog2(NLINES);
  localparam int RW = LW + 1;

  typedef logic [NLINES-1:0] line_vec_t;
  typedef logic [LW-1:0]     line_id_t;
  typedef logic [RW-1:0]     rank_t;

  localparam rank_t RANK_NONE = rank_t'(NLINES);

  // Rotate so that line `base` lands in bit 0.
  function automatic line_vec_t rotate_down(line_vec_t v, line_id_t base);
    line_vec_t r;
    for (int k = 0; k < NLINES; k++)
      r[k] = v[(k + int'(base)) % NLINES];
    return r;
  endfunction

  // Rank of the best set bit, counted from base; NLINES when empty.
  function automatic rank_t best_rank(line_vec_t v, line_id_t base);
    line_vec_t r;
    rank_t res;
    r = rotate_down(v, base);
    res = RANK_NONE;
    for (int k = NLINES - 1; k >= 0; k--)
      if (r[k]) res = rank_t'(k);
    return res;
  endfunction

  function automatic line_id_t rank_to_line(rank_t rk, line_id_t base);
    return line_id_t'(rk[LW-1:0] + base);
  endfunction

  function automatic line_id_t next_line(line_id_t l);
    return line_id_t'(l + 1'b1);
  endfunction
endpackage

// File: rtl/irq_capture.sv
module irq_capture
  import irq_res_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  line_vec_t req_in,
  input  line_vec_t trig_level,
  input  line_vec_t ack_clr,
  output line_vec_t pend_q
);
  line_vec_t prev_q;

  for (genvar i = 0; i < NLINES; i++) begin : g_line
    logic rise_w;
    assign rise_w = req_in[i] & ~prev_q[i];

    always_ff @(posedge clk) begin
      if (rst) begin
        pend_q[i] <= 1'b0;
        prev_q[i] <= 1'b0;
      end else begin
        prev_q[i] <= req_in[i];
        if (trig_level[i])
          pend_q[i] <= req_in[i];
        else if (rise_w)
          pend_q[i] <= 1'b1;
        else if (ack_clr[i])
          pend_q[i] <= 1'b0;
      end
    end

    // R1
    level_follow_chk: assert property (@(posedge clk) disable iff (rst)
      ($past(!rst) && $past(trig_level[i])) |-> (pend_q[i] == $past(req_in[i])));

    // R2
    edge_hold_chk: assert property (@(posedge clk) disable iff (rst)
      ($past(!rst) && $past(!trig_level[i]) && $fell(pend_q[i])) |-> $past(ack_clr[i]));
  end
endmodule

// File: rtl/irq_inservice.sv
module irq_inservice
  import irq_res_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      ack_go,
  input  line_id_t  ack_line,
  input  logic      auto_eoi,
  input  logic      rot_on_aeoi,
  input  logic      serv_clr,
  input  line_id_t  serv_clr_line,
  input  logic      base_load,
  input  line_id_t  base_val,
  output line_vec_t serv_q,
  output line_id_t  base_q
);
  logic set_go, rot_go;
  assign set_go = ack_go & ~auto_eoi;
  assign rot_go = ack_go & auto_eoi & rot_on_aeoi;

  for (genvar i = 0; i < NLINES; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst)
        serv_q[i] <= 1'b0;
      else if (set_go && ack_line == line_id_t'(i))
        serv_q[i] <= 1'b1;
      else if (serv_clr && serv_clr_line == line_id_t'(i))
        serv_q[i] <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)
      base_q <= '0;
    else if (rot_go)
      base_q <= next_line(ack_line);
    else if (base_load)
      base_q <= base_val;
  end

  // R6
  ack_marks_chk: assert property (@(posedge clk) disable iff (rst)
    set_go |=> serv_q[$past(ack_line)]);

  // R7
  aeoi_nomark_chk: assert property (@(posedge clk) disable iff (rst)
    (ack_go && auto_eoi) |=> ((serv_q & ~$past(serv_q)) == '0));

  // R8
  clr_drops_chk: assert property (@(posedge clk) disable iff (rst)
    (serv_clr && !(set_go && ack_line == serv_clr_line)) |=> !serv_q[$past(serv_clr_line)]);
endmodule

// File: rtl/irq_prio_scan.sv
module irq_prio_scan
  import irq_res_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  line_vec_t pend,
  input  line_vec_t mask_in,
  input  line_vec_t serv,
  input  line_id_t  base,
  input  logic      nest_special,
  input  logic      is_master,
  output logic      win_valid,
  output line_id_t  win_line
);
  localparam line_id_t CASCADE_LINE = line_id_t'(2);

  line_vec_t cand_w, serv_eff_w;
  rank_t     req_rank_w, serv_rank_w;

  assign cand_w = pend & ~mask_in;

  always_comb begin
    serv_eff_w = serv;
    if (nest_special && is_master) serv_eff_w[CASCADE_LINE] = 1'b0;
  end

  assign req_rank_w  = best_rank(cand_w, base);
  assign serv_rank_w = best_rank(serv_eff_w, base);
  assign win_valid   = (req_rank_w != RANK_NONE) && (req_rank_w < serv_rank_w);
  assign win_line    = rank_to_line(req_rank_w, base);

  // R3
  win_is_candidate_chk: assert property (@(posedge clk) disable iff (rst)
    win_valid |-> (pend[win_line] && !mask_in[win_line]));

  // R4
  win_not_serviced_chk: assert property (@(posedge clk) disable iff (rst)
    win_valid |-> !serv_eff_w[win_line]);
endmodule

// File: rtl/irq_resolver.sv
module irq_resolver
  import irq_res_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic [7:0] req_in,
  input  logic [7:0] trig_level,
  input  logic [7:0] mask_in,
  input  logic       base_load,
  input  logic [2:0] base_val,
  input  logic       nest_special,
  input  logic       is_master,
  input  logic       auto_eoi,
  input  logic       rot_on_aeoi,
  input  logic       ack,
  input  logic       serv_clr,
  input  logic [2:0] serv_clr_line,
  output logic       win_valid,
  output logic [2:0] win_line,
  output logic [7:0] pend_vec,
  output logic [7:0] serv_vec
);
  line_vec_t pend_w, serv_w, ack_clr_w;
  line_id_t  base_w, line_w;
  logic      valid_w, ack_go_w;

  assign ack_go_w = ack & valid_w;

  for (genvar i = 0; i < NLINES; i++) begin : g_clr
    assign ack_clr_w[i] = ack_go_w && (line_w == line_id_t'(i));
  end

  irq_capture u_cap (
    .clk(clk), .rst(rst), .req_in(req_in), .trig_level(trig_level),
    .ack_clr(ack_clr_w), .pend_q(pend_w)
  );

  irq_inservice u_isv (
    .clk(clk), .rst(rst), .ack_go(ack_go_w), .ack_line(line_w),
    .auto_eoi(auto_eoi), .rot_on_aeoi(rot_on_aeoi),
    .serv_clr(serv_clr), .serv_clr_line(serv_clr_line),
    .base_load(base_load), .base_val(base_val),
    .serv_q(serv_w), .base_q(base_w)
  );

  irq_prio_scan u_scan (
    .clk(clk), .rst(rst), .pend(pend_w), .mask_in(mask_in), .serv(serv_w),
    .base(base_w), .nest_special(nest_special), .is_master(is_master),
    .win_valid(valid_w), .win_line(line_w)
  );

  assign win_valid = valid_w;
  assign win_line  = line_w;
  assign pend_vec  = pend_w;
  assign serv_vec  = serv_w;

  // R11
  idle_ack_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && $past(ack && !valid_w && !serv_clr && !base_load)) |->
      ($stable(serv_w) && $stable(base_w)));

  // R10
  reset_clear_chk: assert property (@(posedge clk)
    $past(rst) |-> (pend_w == '0 && serv_w == '0 && base_w == '0));
endmodule

// File: tb/sim_irq_resolver.sv
module sim_irq_resolver;
  logic clk = 0;
  logic rst;
  logic [7:0] req_in, trig_level, mask_in;
  logic base_load, nest_special, is_master, auto_eoi, rot_on_aeoi, ack, serv_clr;
  logic [2:0] base_val, serv_clr_line;
  logic win_valid;
  logic [2:0] win_line;
  logic [7:0] pend_vec, serv_vec;

  int checks = 0, fails = 0;
  logic [7:0] m_pend, m_serv, m_prev;
  logic [2:0] m_base;
  logic e_valid;
  logic [2:0] e_line;

  always #5 clk = ~clk;

  irq_resolver u0 (.*);

  // Reference winner: walk lines in circular order from the base.
  task automatic model_win();
    logic [7:0] se;
    int rq, rs;
    se = m_serv;
    if (nest_special && is_master) se[2] = 1'b0;
    rq = 8; rs = 8;
    for (int d = 7; d >= 0; d--) begin
      if (m_pend[(m_base + d) % 8] && !mask_in[(m_base + d) % 8]) rq = d;
      if (se[(m_base + d) % 8]) rs = d;
    end
    e_valid = (rq < rs);
    e_line = 3'((m_base + rq) % 8);
  endtask

  task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  // Compare after inputs settle, then advance the model across the edge.
  task automatic step();
    logic go;
    #1;
    model_win();
    check("R1/R2 pend", pend_vec, m_pend);
    check("R6/R8 serv", serv_vec, m_serv);
    check("R4/R5 valid", {7'd0, win_valid}, {7'd0, e_valid});
    if (e_valid) check("R3/R7/R9 line", {5'd0, win_line}, {5'd0, e_line});
    go = ack && e_valid;   // R11: ack without a winner does nothing
    @(posedge clk);
    if (rst) begin
      m_pend = 0; m_serv = 0; m_prev = 0; m_base = 0;   // R10
    end else begin
      for (int i = 0; i < 8; i++) begin
        if (trig_level[i]) m_pend[i] = req_in[i];
        else if (req_in[i] && !m_prev[i]) m_pend[i] = 1'b1;
        else if (go && e_line == 3'(i)) m_pend[i] = 1'b0;
      end
      m_prev = req_in;
      if (serv_clr && !(go && !auto_eoi && e_line == serv_clr_line)) m_serv[serv_clr_line] = 1'b0;
      if (go && !auto_eoi) m_serv[e_line] = 1'b1;
      if (go && auto_eoi && rot_on_aeoi) m_base = e_line + 3'd1;
      else if (base_load) m_base = base_val;
    end
    @(negedge clk);
  endtask

  task automatic idle();
    req_in = 0; trig_level = 0; mask_in = 0; base_load = 0; base_val = 0;
    nest_special = 0; is_master = 0; auto_eoi = 0; rot_on_aeoi = 0;
    ack = 0; serv_clr = 0; serv_clr_line = 0;
  endtask

  initial begin
    #2000000;
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    m_pend = 0; m_serv = 0; m_prev = 0; m_base = 0;
    idle(); rst = 1;
    @(negedge clk); step(); step();
    rst = 0;
    check("R10 reset pend", pend_vec, 8'h00);
    check("R10 reset serv", serv_vec, 8'h00);

    // R2: edge line 5 rises then falls; pending must persist.
    req_in = 8'h20; step(); req_in = 8'h00; step(); step();
    check("R2 edge held", pend_vec, 8'h20);
    // R1: level line 1 follows input.
    trig_level = 8'h02; req_in = 8'h02; step(); req_in = 8'h00; step();
    // R6/R4: ack line 5, then a lower-ranked request stays blocked.
    ack = 1; step(); ack = 0;
    check("R6 serv set", serv_vec, 8'h20);
    req_in = 8'h80; step(); step();
    check("R4 blocked", {7'd0, win_valid}, 8'h00);
    // R8: clear in-service and line 7 wins.
    serv_clr = 1; serv_clr_line = 3'd5; step(); serv_clr = 0; step();
    check("R8 clear", {7'd0, win_valid}, 8'h01);
    // R7: auto EOI with rotation, R9 load in same cycle loses.
    auto_eoi = 1; rot_on_aeoi = 1; base_load = 1; base_val = 3'd3; ack = 1; step();
    idle(); step(); step();
    // R5: special nesting on master ignores in-service line 2.
    is_master = 1; nest_special = 1; req_in = 8'h04; step(); ack = 1; step(); ack = 0;
    req_in = 8'h00; step(); req_in = 8'h04; step(); step();
    check("R5 cascade", {7'd0, win_valid}, 8'h01);
    idle(); rst = 1; step(); rst = 0;

    for (int n = 0; n < 4000; n++) begin
      req_in = 8'($urandom); 
      if ($urandom % 16 == 0) trig_level = 8'($urandom);
      if ($urandom % 8 == 0) mask_in = 8'($urandom) & 8'($urandom);
      base_load = ($urandom % 10 == 0); base_val = 3'($urandom);
      if ($urandom % 50 == 0) begin nest_special = 1'($urandom); is_master = 1'($urandom); end
      if ($urandom % 40 == 0) begin auto_eoi = 1'($urandom); rot_on_aeoi = 1'($urandom); end
      ack = ($urandom % 3 == 0);
      serv_clr = ($urandom % 4 == 0); serv_clr_line = 3'($urandom);
      rst = ($urandom % 500 == 0);
      step();
    end
    rst = 0;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule